// File: doc/BRIEF.md
# Glitch-Free Triple Output Clock Gate

This block stops and restarts three output clocks, each taken from its own free-running source clock, without ever letting a shortened or lengthened pulse reach an output. Two of the channels serve fast differential-path clocks and the third serves a slower reference clock. The block treats all three the same way. Each channel has an asynchronous, active-high hardware enable pin and a register enable bit from elsewhere on the chip. The channel runs only while both are high. Pulling either one low stops that channel, and the other channels keep running.

Each channel brings its request into its own source clock domain through a synchroniser. It then registers the request on the falling source edge and ANDs it with the source clock, so the gate can only open or close while the clock is low. A stopped output is parked low. A per-channel status flag goes high on the rising edge where the gated clock produces its first pulse, and it drops once the output has stopped. A single active-low reset is asserted asynchronously and released separately in each clock domain.

Top module: `clkgate_trio`

## Requirements
- R1: While reset is low, every gated output and every running flag is low.
- R2: A channel toggles only while both its enable pin and its register enable bit are high. With the pin high and the bit low, the output makes no rising edge, and setting the bit restarts it.
- R3: Driving either the pin or the register bit of a channel low stops that channel's output.
- R4: The channels are independent: stopping one channel leaves the pulse count of the others unchanged, one gated pulse per source period.
- R5: After the enable request of a channel goes high, the first gated rising edge comes on source rising edge 2 to 6 after the request, counting from the first source edge after the change.
- R6: Every high pulse on a gated output lasts exactly one source high phase. No runt or stretched pulse appears, whether the channel is starting, stopping or toggling quickly.
- R7: After a stop, the output finishes its current pulse and then stays low for as long as the channel is disabled.
- R8: The running flag of a channel is high during a source high phase exactly when the gated output is high in that phase. It rises with the first gated pulse and falls after the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NUM_OUT | Free-running source clock of each channel (bit 0 and 1: differential-path clocks, bit 2: reference clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| en_pin | input | NUM_OUT | Asynchronous active-high hardware enable per channel |
| en_reg | input | NUM_OUT | Register enable bit per channel, active high |
| gclk_out | output | NUM_OUT | Gated clock per channel, parked low when stopped |
| running | output | NUM_OUT | High while the channel's gated clock is toggling |

## Verification
A stuck or wrongly timed falling-edge gate register would show as a gated pulse whose width differs from the source high phase. It would appear on the first start or stop after the fault, within one source period. A broken synchroniser or AND term would show as a channel that starts outside the 2 to 6 edge window, or that keeps toggling while one of its two enables is low. That becomes visible within a few source cycles of the enable change. A running flag driven from the wrong stage would disagree with the gated output on the edge where the output starts or stops.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  // number of gated channels and synchroniser depth shared by the block
  localparam int unsigned CG_NUM_OUT    = 3;
  localparam int unsigned CG_SYNC_DEPTH = 2;

  // per-channel gate phase, derived from gate and status registers
  typedef enum logic [1:0] {
    GATE_IDLE    = 2'b00,
    GATE_OPENING = 2'b01,
    GATE_CLOSING = 2'b10,
    GATE_OPEN    = 2'b11
  } gate_phase_e;
endpackage

// File: rtl/cg_rst_sync.sv
module cg_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_nxt;

  // ones shift in after release; reset clears all stages at once
  always_comb begin
    stage_nxt = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign rst_n_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[DEPTH-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/cg_chan.sv
module cg_chan
  import clkgate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = CG_SYNC_DEPTH
) (
  input  logic src_clk,
  input  logic arst_n,
  input  logic en_pin,
  input  logic en_reg,
  output logic gclk,
  output logic run
);
  logic        rst_n_loc;
  logic        en_req;
  logic        en_sync;
  logic        gate_q;
  logic        gate_nxt;
  logic        gate_ce;
  logic        run_q;
  logic        run_nxt;
  logic        run_ce;
  gate_phase_e phase;

  cg_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst (
    .clk        (src_clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_loc)
  );

  // both enables must agree; the combined request crosses as one bit
  assign en_req = en_pin & en_reg;

  cg_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (src_clk),
    .rst_n (rst_n_loc),
    .d     (en_req),
    .q     (en_sync)
  );

  // phase of the channel: gate register versus status register
  always_comb begin
    phase = gate_phase_e'({run_q, gate_q});
  end

  // gate register: loads on the falling edge, only when the request differs
  always_comb begin
    gate_ce  = (en_sync != gate_q);
    gate_nxt = gate_ce ? en_sync : gate_q;
  end

  always_ff @(negedge src_clk or negedge rst_n_loc) begin
    if (!rst_n_loc) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_nxt;
    end
  end

  // status follows the gate on the next rising edge, which is the edge
  // carrying the first (or no longer carrying a) gated pulse
  always_comb begin
    run_ce  = (phase == GATE_OPENING) || (phase == GATE_CLOSING);
    run_nxt = run_ce ? gate_q : run_q;
  end

  always_ff @(posedge src_clk or negedge rst_n_loc) begin
    if (!rst_n_loc) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
    end
  end

  // gate changes only while the source is low, so pulses stay whole
  assign gclk = src_clk & gate_q;
  assign run  = run_q;
endmodule

// File: rtl/clkgate_trio.sv
module clkgate_trio
  import clkgate_pkg::*;
#(
  parameter int unsigned NUM_OUT    = CG_NUM_OUT,
  parameter int unsigned SYNC_DEPTH = CG_SYNC_DEPTH
) (
  input  logic [NUM_OUT-1:0] src_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_pin,
  input  logic [NUM_OUT-1:0] en_reg,
  output logic [NUM_OUT-1:0] gclk_out,
  output logic [NUM_OUT-1:0] running
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    cg_chan #(.SYNC_DEPTH(SYNC_DEPTH)) u_chan (
      .src_clk (src_clk[g]),
      .arst_n  (rst_n),
      .en_pin  (en_pin[g]),
      .en_reg  (en_reg[g]),
      .gclk    (gclk_out[g]),
      .run     (running[g])
    );
  end
endmodule

// File: rtl/clkgate_trio_chk.sv
module clkgate_trio_chk #(
  parameter int unsigned NUM_OUT = 3
) (
  input logic [NUM_OUT-1:0] src_clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] en_pin,
  input logic [NUM_OUT-1:0] en_reg,
  input logic [NUM_OUT-1:0] gclk_out,
  input logic [NUM_OUT-1:0] running
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    logic en_both;
    assign en_both = en_pin[g] & en_reg[g];

    // R1: status held low throughout reset
    assert_reset_quiet_R1: assert property (@(posedge src_clk[g])
      !rst_n |-> !running[g]);

    // R3: request low for four edges means the channel reports stopped
    assert_stop_on_low_R3: assert property (@(posedge src_clk[g])
      disable iff (!rst_n)
      (!en_both && !$past(en_both) && !$past(en_both, 2) && !$past(en_both, 3))
        |-> !running[g]);

    // R5: request high for seven edges means the channel is running
    assert_resume_bound_R5: assert property (@(posedge src_clk[g])
      disable iff (!rst_n)
      (en_both && $past(en_both) && $past(en_both, 2) && $past(en_both, 3) &&
       $past(en_both, 4) && $past(en_both, 5) && $past(en_both, 6))
        |-> running[g]);

    // R8: a running channel has its output high through each high phase
    assert_flag_means_pulse_R8: assert property (@(negedge src_clk[g])
      disable iff (!rst_n)
      running[g] |-> gclk_out[g]);

    // R8: a stopped channel shows no pulse in the high phase
    assert_idle_means_quiet_R8: assert property (@(negedge src_clk[g])
      disable iff (!rst_n)
      !running[g] |-> !gclk_out[g]);
  end
endmodule

bind clkgate_trio clkgate_trio_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .src_clk  (src_clk),
  .rst_n    (rst_n),
  .en_pin   (en_pin),
  .en_reg   (en_reg),
  .gclk_out (gclk_out),
  .running  (running)
);

// File: tb/sim_clkgate_trio.sv
`timescale 1ns/1ps
module sim_clkgate_trio;
  localparam int N = 3;

  logic         clk0, clk1, clk2;
  logic         rst_n;
  logic [N-1:0] en_pin;
  logic [N-1:0] en_reg;
  logic [N-1:0] gclk_out;
  logic [N-1:0] running;
  logic [N-1:0] src_clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  assign src_clk = {clk2, clk1, clk0};

  // 50 MHz main clock, plus two other source rates
  initial clk0 = 0;
  always #10 clk0 = ~clk0;
  initial clk1 = 0;
  always #8 clk1 = ~clk1;
  initial clk2 = 0;
  always #20 clk2 = ~clk2;

  clkgate_trio u0 (
    .src_clk  (src_clk),
    .rst_n    (rst_n),
    .en_pin   (en_pin),
    .en_reg   (en_reg),
    .gclk_out (gclk_out),
    .running  (running)
  );

  // pulse monitors: count rising edges and measure every high width
  for (genvar g = 0; g < N; g++) begin : mon
    realtime t_rise;
    realtime half;
    int      edges;
    int      bad_w;
    bit      armed;
    initial begin
      edges = 0; bad_w = 0; armed = 0; t_rise = 0;
      half = (g == 0) ? 10.0 : ((g == 1) ? 8.0 : 20.0);
    end
    always @(posedge gclk_out[g]) begin
      t_rise = $realtime;
      edges++;
      armed = 1;
    end
    always @(negedge gclk_out[g]) begin
      if (armed) begin
        realtime w;
        w = $realtime - t_rise;
        if (w < half - 0.01 || w > half + 0.01) bad_w++;
      end
    end
  end

  function automatic int edges_of(input int i);
    case (i)
      0: return mon[0].edges;
      1: return mon[1].edges;
      default: return mon[2].edges;
    endcase
  endfunction

  function automatic int badw_of(input int i);
    case (i)
      0: return mon[0].bad_w;
      1: return mon[1].bad_w;
      default: return mon[2].bad_w;
    endcase
  endfunction

  task automatic wait_src(input int i);
    case (i)
      0: @(posedge clk0);
      1: @(posedge clk1);
      default: @(posedge clk2);
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1: outputs quiet during reset
  task automatic t_reset;
    #50;
    chk(gclk_out == '0, "R1 gclk in reset", int'(gclk_out), 0);
    chk(running == '0, "R1 running in reset", int'(running), 0);
  endtask

  // R5/R8/R2: start a channel and measure latency and pulse count
  task automatic t_resume(input int i);
    int n;
    int e0;
    n = 0;
    wait_src(i); #2;
    en_pin[i] = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      wait_src(i); #1;
      if (gclk_out[i]) begin
        n = k;
        break;
      end
    end
    chk(n >= 2 && n <= 6, "R5 resume latency", n, 3);
    chk(running[i] == 1'b1, "R8 flag with first pulse", int'(running[i]), 1);
    e0 = edges_of(i);
    repeat (10) wait_src(i);
    #1;
    chk(edges_of(i) - e0 == 10, "R2 both enables high toggles", edges_of(i) - e0, 10);
  endtask

  // R3/R7/R8: stop via the pin and confirm it stays parked low
  task automatic t_stop_pin(input int i);
    int e0;
    int high_seen;
    high_seen = 0;
    wait_src(i); #2;
    en_pin[i] = 1'b0;
    repeat (6) wait_src(i);
    #1;
    chk(running[i] == 1'b0, "R8 flag drops after stop", int'(running[i]), 0);
    e0 = edges_of(i);
    for (int k = 0; k < 10; k++) begin
      wait_src(i); #1;
      if (gclk_out[i]) high_seen++;
    end
    chk(edges_of(i) == e0, "R3 pin low stops output", edges_of(i) - e0, 0);
    chk(high_seen == 0, "R7 parked low", high_seen, 0);
  endtask

  // R2: register bit low keeps the channel off with the pin high
  task automatic t_reg_gate(input int i);
    int e0;
    int n;
    n = 0;
    en_reg[i] = 1'b0;
    wait_src(i); #2;
    en_pin[i] = 1'b1;
    e0 = edges_of(i);
    repeat (12) wait_src(i);
    #1;
    chk(edges_of(i) == e0, "R2 bit low blocks pin", edges_of(i) - e0, 0);
    chk(running[i] == 1'b0, "R2 flag stays low", int'(running[i]), 0);
    en_reg[i] = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      wait_src(i); #1;
      if (gclk_out[i]) begin
        n = k;
        break;
      end
    end
    chk(n >= 2 && n <= 6, "R2 bit high restarts", n, 3);
  endtask

  // R3/R4: stop one channel by its register bit; the others keep going
  task automatic t_indep;
    int e0, e1, e2;
    en_reg[1] = 1'b0;
    repeat (6) wait_src(1);
    wait_src(0); #1;
    e0 = edges_of(0); e1 = edges_of(1); e2 = edges_of(2);
    repeat (10) wait_src(0);
    #1;
    chk(edges_of(0) - e0 == 10, "R4 channel 0 unaffected", edges_of(0) - e0, 10);
    chk(edges_of(2) - e2 >= 4 && edges_of(2) - e2 <= 6, "R4 channel 2 unaffected",
        edges_of(2) - e2, 5);
    chk(edges_of(1) == e1, "R3 bit low stops channel 1", edges_of(1) - e1, 0);
    chk(running == 3'b101, "R4 flags per channel", int'(running), 5);
    en_reg[1] = 1'b1;
  endtask

  // R6: rapid toggling at awkward offsets never yields a partial pulse
  task automatic t_toggle;
    int d;
    d = 3;
    for (int k = 0; k < 40; k++) begin
      #(d);
      en_pin[k % N] = ~en_pin[k % N];
      d = (d * 7 + 5) % 53 + 1;
    end
    en_pin = '1;
    repeat (20) wait_src(2);
    for (int i = 0; i < N; i++) begin
      chk(badw_of(i) == 0, "R6 pulse width intact", badw_of(i), 0);
    end
    chk(running == 3'b111, "R8 all running after toggling", int'(running), 7);
  endtask

  initial begin
    rst_n  = 1'b0;
    en_pin = '0;
    en_reg = '1;
    t_reset();
    #37;
    rst_n = 1'b1;
    repeat (5) wait_src(2);
    for (int i = 0; i < N; i++) t_resume(i);
    t_stop_pin(0);
    t_resume(0);
    t_indep();
    t_stop_pin(2);
    t_reg_gate(2);
    t_toggle();
    for (int i = 0; i < N; i++) t_stop_pin(i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule